// File: doc/BRIEF.md
# XOR-Equation Metadata Address Generator

This block turns a pixel coordinate (x, y, z, sample) into a byte address inside a compression-metadata surface. The address is not a fixed function of the coordinate. Software loads a per-bit equation. Each low address bit is then the parity of up to five chosen coordinate bits. The upper address bits come from a linear meta-block index, which is derived from the surface pitch, the surface height and power-of-two block dimensions. The block index is one more selectable coordinate, so it can also take part in the low-bit parities.

A request is a single-cycle pulse on `req_valid` with the coordinate applied. Two cycles later the block presents a registered address, a nibble bit position and a one-cycle `out_valid`. The first stage forms the block index. The second stage evaluates the parities, merges in the block-index bits and applies a pipe swizzle. The swizzle is an XOR of a masked pipe value placed at a programmable interleave position. The equation and the other configuration inputs are held steady while requests are in flight. A new request may be issued every cycle.

Top module: `xeq_meta_addr`

## Requirements
- R1: After reset, `out_valid`, `addr` and `nib_pos` are all zero.
- R2: A `req_valid` pulse at clock edge k yields `out_valid` high for exactly the cycle after edge k+2. Requests on consecutive cycles each yield their own result, in order. While `out_valid` is low, `addr` and `nib_pos` hold their last values.
- R3: Each term of the equation is TW=8 bits wide: bits [7:5] hold the dimension code and bits [4:0] hold the bit ordinal. Term c of address bit b sits at bit offset (b*5+c)*8 of `eq_cfg`. The dimension codes are 0=x, 1=y, 2=z, 3=sample and 4=block index. For b < num_bits-1, raw bit b is the XOR of coordinate bit [ordinal] of the selected dimension, taken over all five terms whose code is 4 or less.
- R4: The block index is zb*slice_blocks + yb*pitch_blocks + xb, computed modulo 2^32. Here xb = x>>bw, yb = y>>bh and zb = z>>bd, where bw, bh and bd are the log2 block width, height and depth inputs. pitch_blocks = pitch>>bw and slice_blocks = (height>>bh)*pitch_blocks.
- R5: Raw bits num_bits-1 and up are filled with the block index shifted right by the ordinal of term 0 of bit num_bits-1, with the fill starting at bit num_bits-1. The dimension code of that term is not consulted. `num_bits` must lie in 1..32.
- R6: `nib_pos` is 4 when raw bit 0 is 1, and 0 when raw bit 0 is 0.
- R7: `addr` = (raw >> 1) XOR ((pipe_xor AND (2^pipe_bits - 1)) << (8 + ilv_sel)).
- R8: A term whose dimension code is 5, 6 or 7 has no effect on `addr` or `nib_pos`, whatever its ordinal. The exception is the ordinal of term 0 of bit num_bits-1 (see R5).
- R9: Take an equation in which only raw bit 1 depends on sample bit 0, through one term, and no other term selects the sample. For any pixel, the address for sample 0 is then exactly one less than the address for sample 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eq_cfg | input | 1280 | Equation: 32 bits x 5 terms x 8 bits |
| num_bits | input | 6 | Number of equation bits, 1..32 |
| pitch | input | 16 | Surface pitch in pixels |
| height | input | 16 | Surface height in pixels |
| blk_w_log2 | input | 5 | log2 of meta-block width |
| blk_h_log2 | input | 5 | log2 of meta-block height |
| blk_d_log2 | input | 5 | log2 of meta-block depth |
| pipe_xor | input | 4 | Pipe swizzle value |
| pipe_bits | input | 3 | Number of pipe swizzle bits in use, 0..4 |
| ilv_sel | input | 2 | Interleave select; swizzle shift is 8+ilv_sel |
| req_valid | input | 1 | One-cycle request strobe |
| x | input | 16 | Pixel x |
| y | input | 16 | Pixel y |
| z | input | 16 | Slice |
| smp | input | 16 | Sample index |
| out_valid | output | 1 | Result valid, one cycle |
| addr | output | 32 | Metadata byte address |
| nib_pos | output | 3 | Nibble bit position, 0 or 4 |

## Verification
The bench uses the default parameters: 32 equation bits, 16-bit coordinates and a 4-bit pipe swizzle. With these values every ordinal from 0 to 31 can reach every coordinate, including the zero-extended upper bits. The 32-bit block index can wrap, and the swizzle can be shifted as far as bit 14. Random equations mix used terms with ignored ones over the whole range of equation lengths, from a single bit up to 32. Directed cases then check the block-index arithmetic with known numbers, the swizzle masks and the sample-adjacency rule.

// File: rtl/xeq_meta_addr.sv
module xeq_meta_addr #(
  parameter int MAX_BITS = 32,
  parameter int CW       = 16,
  parameter int PXW      = 4,
  parameter int LW       = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MAX_BITS*5*(3+$clog2(MAX_BITS))-1:0] eq_cfg,
  input  logic [$clog2(MAX_BITS+1)-1:0] num_bits,
  input  logic [CW-1:0]                 pitch,
  input  logic [CW-1:0]                 height,
  input  logic [LW-1:0]                 blk_w_log2,
  input  logic [LW-1:0]                 blk_h_log2,
  input  logic [LW-1:0]                 blk_d_log2,
  input  logic [PXW-1:0]                pipe_xor,
  input  logic [$clog2(PXW+1)-1:0]      pipe_bits,
  input  logic [1:0]                    ilv_sel,
  input  logic                          req_valid,
  input  logic [CW-1:0]                 x,
  input  logic [CW-1:0]                 y,
  input  logic [CW-1:0]                 z,
  input  logic [CW-1:0]                 smp,
  output logic                          out_valid,
  output logic [MAX_BITS-1:0]           addr,
  output logic [2:0]                    nib_pos
);
  localparam int BW  = MAX_BITS;
  localparam int OW  = $clog2(MAX_BITS);
  localparam int TW  = 3 + OW;
  localparam int NBW = $clog2(MAX_BITS+1);
  localparam int PMW = PXW + 1;

  // stage 1: block index
  logic [CW-1:0] pb, hb, xb, yb, zb;
  logic [BW-1:0] slice_blk, bidx_c;
  assign pb = pitch >> blk_w_log2;
  assign hb = height >> blk_h_log2;
  assign xb = x >> blk_w_log2;
  assign yb = y >> blk_h_log2;
  assign zb = z >> blk_d_log2;
  assign slice_blk = BW'(hb) * BW'(pb);
  assign bidx_c = BW'(zb) * slice_blk + BW'(yb) * BW'(pb) + BW'(xb);

  logic          s1_v;
  logic [CW-1:0] s1_x, s1_y, s1_z, s1_s;
  logic [BW-1:0] s1_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_x <= '0;
      s1_y <= '0;
      s1_z <= '0;
      s1_s <= '0;
      s1_b <= '0;
    end else begin
      s1_v <= req_valid;
      if (req_valid) begin
        s1_x <= x;
        s1_y <= y;
        s1_z <= z;
        s1_s <= smp;
        s1_b <= bidx_c;
      end
    end
  end

  // stage 2: parity, merge, swizzle
  logic [5*BW-1:0] cv;
  assign cv = {s1_b, BW'(s1_s), BW'(s1_z), BW'(s1_y), BW'(s1_x)};

  function automatic logic pick(input logic [2:0] d, input logic [OW-1:0] o,
                                input logic [5*BW-1:0] v);
    if (d > 3'd4) return 1'b0;
    return v[int'(d)*BW + int'(o)];
  endfunction

  logic [BW-1:0] par;
  always_comb begin
    par = '0;
    for (int b = 0; b < MAX_BITS; b++)
      for (int c = 0; c < 5; c++)
        par[b] = par[b] ^ pick(eq_cfg[(b*5+c)*TW+OW +: 3], eq_cfg[(b*5+c)*TW +: OW], cv);
  end

  logic [NBW-1:0] lst;
  logic [OW-1:0]  ord_last;
  logic [BW-1:0]  low_mask, raw, swz, addr_c;
  logic [PMW-1:0] pm;
  logic [PXW-1:0] pmask;
  assign lst      = num_bits - NBW'(1);
  assign ord_last = eq_cfg[int'(lst)*5*TW +: OW];
  assign low_mask = (BW'(1) << lst) - BW'(1);
  assign raw      = (par & low_mask) | ((s1_b >> ord_last) << lst);
  assign pm       = PMW'(1) << pipe_bits;
  assign pmask    = PXW'(pm - PMW'(1));
  assign swz      = BW'(pipe_xor & pmask) << (4'd8 + 4'(ilv_sel));
  assign addr_c   = (raw >> 1) ^ swz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      nib_pos   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        addr    <= addr_c;
        nib_pos <= {raw[0], 2'b00};
      end
    end
  end
endmodule

// File: rtl/xeq_meta_addr_chk.sv
module xeq_meta_addr_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          out_valid,
  input logic [AW-1:0] addr,
  input logic [2:0]    nib_pos
);
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid, 2)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(addr) && $stable(nib_pos)); // R2
  AST_NIB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nib_pos == 3'd0 || nib_pos == 3'd4)); // R6
endmodule

bind xeq_meta_addr xeq_meta_addr_chk #(.AW(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .out_valid(out_valid), .addr(addr), .nib_pos(nib_pos)
);

// File: tb/xeq_meta_addr_bench.sv
module xeq_meta_addr_bench;
  localparam int MB = 32, CW = 16, TW = 8, EQW = MB*5*TW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [EQW-1:0] eq = '0;
  logic [5:0]     nb = 6'd1;
  logic [CW-1:0]  pitch = '0, height = '0, x = '0, y = '0, z = '0, smp = '0;
  logic [4:0]     bw = '0, bh = '0, bd = '0;
  logic [3:0]     px = '0;
  logic [2:0]     pbits = '0;
  logic [1:0]     il = '0;
  logic           req = 1'b0;
  logic           out_valid;
  logic [31:0]    addr;
  logic [2:0]     nib_pos;

  xeq_meta_addr u_xeq_meta_addr (
    .clk(clk), .rst_n(rst_n), .eq_cfg(eq), .num_bits(nb), .pitch(pitch), .height(height),
    .blk_w_log2(bw), .blk_h_log2(bh), .blk_d_log2(bd), .pipe_xor(px), .pipe_bits(pbits),
    .ilv_sel(il), .req_valid(req), .x(x), .y(y), .z(z), .smp(smp),
    .out_valid(out_valid), .addr(addr), .nib_pos(nib_pos)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic set_term(input int b, input int c, input int d, input int o);
    eq[(b*5+c)*TW +: TW] = {d[2:0], o[4:0]};
  endtask

  task automatic clear_eq();
    for (int b = 0; b < MB; b++)
      for (int c = 0; c < 5; c++) set_term(b, c, 7, 0);
  endtask

  function automatic logic [34:0] model();
    logic [31:0] pbk, sbk, bi, raw, cvv, pm;
    int d, o, last;
    logic p;
    pbk = 32'(pitch >> bw);
    sbk = 32'(height >> bh) * pbk;
    bi  = 32'(z >> bd) * sbk + 32'(y >> bh) * pbk + 32'(x >> bw);
    raw = 0;
    last = int'(nb) - 1;
    for (int b = 0; b < last; b++) begin
      p = 1'b0;
      for (int c = 0; c < 5; c++) begin
        d = int'(eq[(b*5+c)*TW+5 +: 3]);
        o = int'(eq[(b*5+c)*TW +: 5]);
        case (d)
          0: cvv = 32'(x);
          1: cvv = 32'(y);
          2: cvv = 32'(z);
          3: cvv = 32'(smp);
          4: cvv = bi;
          default: cvv = 0;
        endcase
        p ^= cvv[o];
      end
      raw[b] = p;
    end
    o = int'(eq[last*5*TW +: 5]);
    raw = raw | ((bi >> o) << last);
    pm = (32'd1 << pbits) - 1;
    return {(raw[0] ? 3'd4 : 3'd0), (raw >> 1) ^ ((32'(px) & pm) << (8 + il))};
  endfunction

  task automatic issue(output logic [31:0] a, output logic [2:0] n);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    chk("R2 no early valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R2 valid at latency 2", 64'(out_valid), 64'd1);
    a = addr;
    n = nib_pos;
  endtask

  task automatic run(input string tag);
    logic [34:0] e;
    logic [31:0] a;
    logic [2:0]  n;
    e = model();
    issue(a, n);
    chk({tag, " addr"}, 64'(a), 64'(e[31:0]));
    chk("R6 nib_pos", 64'(n), 64'(e[34:32]));
  endtask

  task automatic rand_cfg();
    for (int b = 0; b < MB; b++)
      for (int c = 0; c < 5; c++)
        set_term(b, c, int'($urandom % 8), ($urandom % 2) ? int'($urandom % 32) : int'($urandom % 8));
    nb = 6'(1 + $urandom % 32);
    pitch = CW'($urandom); height = CW'($urandom);
    bw = 5'($urandom % 7); bh = 5'($urandom % 7); bd = 5'($urandom % 4);
    px = 4'($urandom); pbits = 3'($urandom % 5); il = 2'($urandom);
    x = CW'($urandom); y = CW'($urandom); z = CW'($urandom); smp = CW'($urandom % 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1;
    logic [2:0]  n0, n1;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset addr", 64'(addr), 64'd0);
    chk("R1 reset nib_pos", 64'(nib_pos), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R6 known block index: pb=8 hb=8 slice=64 -> index 155
    clear_eq(); set_term(0, 0, 7, 0);
    nb = 6'd1; pitch = 16'd64; height = 16'd32; bw = 5'd3; bh = 5'd2; bd = 5'd1;
    x = 16'd29; y = 16'd13; z = 16'd5; smp = 0; pbits = 0; px = 4'hF; il = 0;
    issue(a0, n0);
    chk("R4 block index addr", 64'(a0), 64'd77);
    chk("R6 nib set", 64'(n0), 64'd4);
    x = 16'd21;
    issue(a0, n0);
    chk("R4 block index addr x=21", 64'(a0), 64'd77);
    chk("R6 nib clear", 64'(n0), 64'd0);

    // R5 fill position and shift
    x = 16'd29;
    nb = 6'd32; set_term(31, 0, 2, 0);
    issue(a0, n0);
    chk("R5 fill at bit 31", 64'(a0), 64'h4000_0000);
    clear_eq(); nb = 6'd5; set_term(4, 0, 7, 2);
    issue(a0, n0);
    chk("R5 fill shifted by 2", 64'(a0), 64'd304);

    // R3 directed parity
    clear_eq(); nb = 6'd3; set_term(2, 0, 7, 31);
    set_term(0, 0, 0, 3); set_term(0, 3, 1, 0); set_term(1, 2, 3, 1);
    x = 16'd8; y = 16'd0; z = 0; smp = 16'd2;
    issue(a0, n0);
    chk("R3 parity addr", 64'(a0), 64'd1);
    chk("R3 parity nib", 64'(n0), 64'd4);
    y = 16'd1;
    issue(a0, n0);
    chk("R3 parity cancels", 64'(n0), 64'd0);

    // R7 swizzle masks
    clear_eq(); nb = 6'd32; set_term(31, 0, 7, 31);
    x = 0; y = 0; z = 0; smp = 0; px = 4'hF;
    pbits = 3'd2; il = 2'd3;
    issue(a0, n0); chk("R7 two pipe bits at 11", 64'(a0), 64'h1800);
    pbits = 3'd4; il = 2'd0;
    issue(a0, n0); chk("R7 four pipe bits at 8", 64'(a0), 64'h0F00);
    pbits = 3'd0; il = 2'd2;
    issue(a0, n0); chk("R7 no pipe bits", 64'(a0), 64'h0);

    // R2 back-to-back
    rand_cfg();
    begin
      logic [34:0] e0, e1;
      logic [CW-1:0] x2;
      x2 = CW'($urandom);
      e0 = model();
      @(negedge clk) req = 1'b1;
      @(negedge clk) x = x2;
      e1 = model();
      @(negedge clk) req = 1'b0;
      chk("R2 first back-to-back", {out_valid, 32'(addr)}, {1'b1, e0[31:0]});
      @(negedge clk);
      chk("R2 second back-to-back", {out_valid, 32'(addr)}, {1'b1, e1[31:0]});
      @(negedge clk);
      chk("R2 valid drops", 64'(out_valid), 64'd0);
      chk("R2 addr held", 64'(addr), 64'(e1[31:0]));
    end

    // R3 R4 R5 R7 random
    for (int i = 0; i < 250; i++) begin
      rand_cfg();
      run("R3 R4 R5 R7 random");
    end

    // R8 ignored terms
    for (int i = 0; i < 20; i++) begin
      rand_cfg();
      issue(a0, n0);
      for (int b = 0; b < MB; b++)
        for (int c = 0; c < 5; c++)
          if (eq[(b*5+c)*TW+5 +: 3] > 3'd4 && !(b == int'(nb) - 1 && c == 0))
            set_term(b, c, 5 + int'($urandom % 3), int'($urandom % 32));
      issue(a1, n1);
      chk("R8 ignored terms addr", 64'(a1), 64'(a0));
      chk("R8 ignored terms nib", 64'(n1), 64'(n0));
    end

    // R9 sample adjacency
    for (int i = 0; i < 20; i++) begin
      rand_cfg();
      if (nb < 6'd3) nb = 6'd3;
      for (int b = 0; b < MB; b++)
        for (int c = 0; c < 5; c++)
          if (eq[(b*5+c)*TW+5 +: 3] == 3'd3) set_term(b, c, 0, int'($urandom % 16));
      for (int c = 0; c < 5; c++) set_term(1, c, 7, 0);
      set_term(1, 0, 3, 0);
      smp = 0;
      issue(a0, n0);
      smp = 16'd1;
      issue(a1, n1);
      chk("R9 sample 0 one byte below sample 1", 64'(a1 - 32'd1), 64'(a0));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule